// File: doc/BRIEF.md
# Short Forward Branch Write-Back Suppression Controller

This block sits beside the issue and final stages of a dual-issue in-order RISC-V pipeline. It looks at two decoded slots issued together. It recognises the case where the older slot holds a 32-bit conditional branch whose target lies just past the younger slot. When the younger slot also holds a plain ALU operation, the two instructions run side by side as a pair. The branch then never steers fetch. Its outcome at the final stage only decides whether the younger instruction may write its destination register.

Each branch is carried through a parameterised number of stages, `DEPTH`, counted from the issue edge to the final stage. A pair has two outcomes. If the branch resolves not taken, the shadowed instruction writes back. If it resolves taken, that write is cancelled, and in both cases no redirect is raised. A branch that does not form a pair, or that issues while the optimisation is switched off, is handled the ordinary way: when it resolves taken, the block requests a redirect to its target, and that request also kills the younger instruction. A flush caused by an older exception removes every branch in flight, so none of them commits.

Top module: `sfb_pair_ctrl`

## Requirements
- R1: `pair_eligible` is high only when all of the following hold: `s0_valid` and `s1_valid` are both high; slot 0 has opcode bits[6:0]=1100011 and funct3 bits[14:12] other than 010 and 011; `cfg_disable` is low; the branch offset equals 4 plus the length of slot 1. Slot 1 is 4 bytes long when bits[1:0]=11 and 2 bytes long otherwise. So the offset must be 8 for a 32-bit slot 1 and 6 for a 16-bit slot 1.
- R2: Slot 1 qualifies when it is a 32-bit instruction with opcode 0110011, 0010011, 0110111 or 0010111. It also qualifies as a 16-bit load-immediate (bits[1:0]=01, bits[15:13]=010) or a 16-bit register move (bits[1:0]=10, bits[15:12]=1000, bits[6:2] nonzero).
- R3: A slot 1 holding any other instruction, including a load (opcode 0000011) or a store (opcode 0100011), never qualifies. The branch is then handled as an ordinary branch.
- R4: While `cfg_disable` is high, no pair is formed, and a branch issued in that cycle is tracked as an ordinary branch.
- R5: A branch in slot 0 that is present on a rising edge shows `fin_valid` high for exactly one cycle, DEPTH-1 edges later. During that cycle `fin_paired` repeats the `pair_eligible` value from the issue cycle.
- R6: For a pair whose branch resolves taken (`fin_taken` high), `sh_wb_en` is low and `redirect_valid` is low.
- R7: For a pair whose branch resolves not taken, `sh_wb_en` is high when the destination bits[11:7] of slot 1 are nonzero, and `redirect_valid` is low.
- R8: A slot 1 whose destination is x0 still forms a pair, and `sh_wb_en` stays low for it whatever the outcome.
- R9: An unpaired branch that resolves taken raises `redirect_valid`, which also flushes the younger instruction, with `redirect_target` equal to its PC plus its sign-extended B-type offset. If it resolves not taken, no redirect is raised and `sh_wb_en` stays low.
- R10: In a cycle where `flush` is high, `sh_wb_en` and `redirect_valid` are low. No branch tracked in that cycle, or issued in that cycle, ever reaches the final stage.
- R11: After reset, `fin_valid`, `sh_wb_en` and `redirect_valid` are low until a branch reaches the final stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_disable | input | 1 | Turns off pair formation |
| s0_valid | input | 1 | Older issue slot holds an instruction |
| s0_instr | input | 32 | Older slot encoding |
| s0_pc | input | XLEN | Older slot PC |
| s1_valid | input | 1 | Younger issue slot holds an instruction |
| s1_instr | input | 32 | Younger slot encoding (low half for 16-bit forms) |
| flush | input | 1 | Flush from an older exception |
| fin_taken | input | 1 | Outcome of the branch at the final stage |
| pair_eligible | output | 1 | The slots form a suppression pair |
| fin_valid | output | 1 | A tracked branch is at the final stage |
| fin_paired | output | 1 | That branch was issued as a pair |
| sh_wb_en | output | 1 | Write-back enable of the shadowed instruction |
| redirect_valid | output | 1 | Redirect fetch and kill the younger instruction |
| redirect_target | output | XLEN | Redirect destination |

## Verification
Three events can fall in the same cycle: a flush, a branch arriving at the final stage, and a new branch being issued. A flush must override both. It silences the write-back enable and the redirect of the branch at the final stage, and the newly issued branch must never appear at the output. The bench raises `flush` in the exact cycle a tracked branch is at the final stage, and also in cycles where a new branch is being issued. A behavioural queue, aged per cycle, predicts every output on every cycle, and the bench judges the outputs against it. The bench also issues branches back to back, so that one branch resolves in the final stage while the next one is being issued.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int XLEN = 32;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

    typedef struct packed {
        logic            valid;
        logic            paired;
        logic            rd_nz;
        logic [XLEN-1:0] target;
    } trk_entry_t;

    // Instruction is full width when its two low bits are both set.
    function automatic logic is_wide(input logic [1:0] low);
        return low == 2'b11;
    endfunction

    function automatic logic is_cond_branch(input logic [31:0] i);
        return (i[6:0] == OPC_BRANCH) && (i[14:13] != 2'b01);
    endfunction

    function automatic logic [XLEN-1:0] br_offset(input logic [31:0] i);
        return {{(XLEN-13){i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0};
    endfunction

    function automatic logic wide_alu(input logic [6:0] opc);
        return (opc == OPC_OP) || (opc == OPC_OPIMM) ||
               (opc == OPC_LUI) || (opc == OPC_AUIPC);
    endfunction

    function automatic logic narrow_alu(input logic [15:0] h);
        logic li_form;
        logic mv_form;
        li_form = (h[1:0] == 2'b01) && (h[15:13] == 3'b010);
        mv_form = (h[1:0] == 2'b10) && (h[15:12] == 4'b1000) && (h[6:2] != 5'd0);
        return li_form || mv_form;
    endfunction
endpackage

// File: rtl/sfb_slot_decode.sv
module sfb_slot_decode
    import sfb_pkg::*;
(
    input  logic            s0_valid,
    input  logic [31:0]     s0_instr,
    input  logic [XLEN-1:0] s0_pc,
    input  logic            s1_valid,
    input  logic [31:0]     s1_instr,
    input  logic            cfg_disable,
    output logic            issue_br,
    output logic            pair_ok,
    output trk_entry_t      entry
);
    logic            s1_wide;
    logic            s1_alu;
    logic [XLEN-1:0] off;
    logic [XLEN-1:0] want_off;

    always_comb begin
        s1_wide  = is_wide(s1_instr[1:0]);
        s1_alu   = s1_wide ? wide_alu(s1_instr[6:0]) : narrow_alu(s1_instr[15:0]);
        off      = br_offset(s0_instr);
        want_off = s1_wide ? XLEN'(8) : XLEN'(6);
        issue_br = s0_valid && is_cond_branch(s0_instr);
        pair_ok  = issue_br && s1_valid && s1_alu && (off == want_off) && !cfg_disable;
        entry.valid  = issue_br;
        entry.paired = pair_ok;
        entry.rd_nz  = s1_instr[11:7] != 5'd0;
        entry.target = s0_pc + off;
    end
endmodule

// File: rtl/sfb_pair_pipe.sv
module sfb_pair_pipe
    import sfb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       cfg_disable,
    input  trk_entry_t in_entry,
    output trk_entry_t tail
);
    localparam int LAST = DEPTH - 1;

    trk_entry_t stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || flush) stg[0] <= '0;
        else              stg[0] <= in_entry;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || flush) stg[g] <= '0;
            else              stg[g] <= stg[g-1];
        end
    end

    assign tail = stg[LAST];

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !tail.valid);
    a_r4_disabled_unpaired: assert property (@(posedge clk) disable iff (rst)
        (in_entry.valid && cfg_disable) |=> !stg[0].paired);
    a_r5_pair_has_branch: assert property (@(posedge clk) disable iff (rst)
        tail.paired |-> tail.valid);
endmodule

// File: rtl/sfb_final_gate.sv
module sfb_final_gate
    import sfb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  trk_entry_t      fin,
    input  logic            fin_taken,
    input  logic            flush,
    output logic            sh_wb_en,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_target
);
    logic live;

    always_comb begin
        live            = fin.valid && !flush;
        sh_wb_en        = live && fin.paired && !fin_taken && fin.rd_nz;
        redirect_valid  = live && !fin.paired && fin_taken;
        redirect_target = fin.target;
    end

    a_r6_pair_never_redirects: assert property (@(posedge clk) disable iff (rst)
        (fin.valid && fin.paired) |-> !redirect_valid);
    a_r9_redirect_needs_taken: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (fin_taken && fin.valid && !fin.paired));
    a_r10_flush_silences: assert property (@(posedge clk) disable iff (rst)
        flush |-> !(sh_wb_en || redirect_valid));
    a_r8_x0_no_write: assert property (@(posedge clk) disable iff (rst)
        sh_wb_en |-> fin.rd_nz);
endmodule

// File: rtl/sfb_pair_ctrl.sv
module sfb_pair_ctrl
    import sfb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_disable,
    input  logic            s0_valid,
    input  logic [31:0]     s0_instr,
    input  logic [XLEN-1:0] s0_pc,
    input  logic            s1_valid,
    input  logic [31:0]     s1_instr,
    input  logic            flush,
    input  logic            fin_taken,
    output logic            pair_eligible,
    output logic            fin_valid,
    output logic            fin_paired,
    output logic            sh_wb_en,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_target
);
    trk_entry_t new_entry;
    trk_entry_t fin_entry;
    logic       issue_br;

    sfb_slot_decode u_dec (
        .s0_valid    (s0_valid),
        .s0_instr    (s0_instr),
        .s0_pc       (s0_pc),
        .s1_valid    (s1_valid),
        .s1_instr    (s1_instr),
        .cfg_disable (cfg_disable),
        .issue_br    (issue_br),
        .pair_ok     (pair_eligible),
        .entry       (new_entry)
    );

    sfb_pair_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .cfg_disable (cfg_disable),
        .in_entry    (new_entry),
        .tail        (fin_entry)
    );

    sfb_final_gate u_gate (
        .clk             (clk),
        .rst             (rst),
        .fin             (fin_entry),
        .fin_taken       (fin_taken),
        .flush           (flush),
        .sh_wb_en        (sh_wb_en),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target)
    );

    assign fin_valid  = fin_entry.valid;
    assign fin_paired = fin_entry.paired;

    a_r1_pair_needs_branch: assert property (@(posedge clk) disable iff (rst)
        pair_eligible |-> (issue_br && s1_valid && !cfg_disable));
endmodule

// File: tb/sfb_pair_ctrl_test.sv
module sfb_pair_ctrl_test;
    localparam int D = 3;

    logic        clk = 0;
    logic        rst;
    logic        cfg_disable, s0_valid, s1_valid, flush, fin_taken;
    logic [31:0] s0_instr, s1_instr, s0_pc;
    logic        pair_eligible, fin_valid, fin_paired, sh_wb_en, redirect_valid;
    logic [31:0] redirect_target;

    int checks = 0;
    int errors = 0;
    int cyc_n  = 0;

    typedef struct {
        bit          paired;
        bit          rdnz;
        logic [31:0] tgt;
        int          age;
    } ref_t;
    ref_t q[$];

    always #2 clk = ~clk;

    sfb_pair_ctrl #(.DEPTH(D)) uut (
        .clk(clk), .rst(rst), .cfg_disable(cfg_disable),
        .s0_valid(s0_valid), .s0_instr(s0_instr), .s0_pc(s0_pc),
        .s1_valid(s1_valid), .s1_instr(s1_instr), .flush(flush),
        .fin_taken(fin_taken), .pair_eligible(pair_eligible),
        .fin_valid(fin_valid), .fin_paired(fin_paired), .sh_wb_en(sh_wb_en),
        .redirect_valid(redirect_valid), .redirect_target(redirect_target)
    );

    function automatic logic [31:0] mk_br(int off, logic [2:0] f3);
        logic [12:0] im;
        im = 13'(off);
        return {im[12], im[10:5], 5'd2, 5'd1, f3, im[4:1], im[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] mk_w(logic [6:0] opc, logic [4:0] rd);
        return {7'd0, 5'd3, 5'd4, 3'd0, rd, opc};
    endfunction
    function automatic logic [31:0] mk_cli(logic [4:0] rd);
        return {16'hFFFF, 3'b010, 1'b0, rd, 5'd7, 2'b01};
    endfunction
    function automatic logic [31:0] mk_cmv(logic [4:0] rd);
        return {16'h0000, 4'b1000, rd, 5'd9, 2'b10};
    endfunction

    function automatic int b_off(logic [31:0] i);
        logic [12:0] im;
        im = {i[31], i[7], i[30:25], i[11:8], 1'b0};
        return int'($signed(im));
    endfunction
    function automatic bit b_isbr(logic v, logic [31:0] i);
        return v && i[6:0] == 7'h63 && i[14:12] != 3'd2 && i[14:12] != 3'd3;
    endfunction
    function automatic bit b_elig(logic v0, logic [31:0] i0, logic v1,
                                  logic [31:0] i1, logic dis);
        bit w, ok;
        w = i1[1:0] == 2'b11;
        if (w) ok = i1[6:0] inside {7'h33, 7'h13, 7'h37, 7'h17};
        else   ok = (i1[1:0] == 2'b01 && i1[15:13] == 3'b010) ||
                    (i1[1:0] == 2'b10 && i1[15:12] == 4'b1000 && i1[6:2] != 0);
        return b_isbr(v0, i0) && v1 && !dis && ok && b_off(i0) == (w ? 8 : 6);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc_n);
        end
    endtask

    task automatic step(string tag, logic v0, logic [31:0] i0, logic [31:0] pc,
                        logic v1, logic [31:0] i1, logic dis, logic fl, logic tk);
        bit   e_fv, e_fp, e_wb, e_rd;
        logic [31:0] e_tg;
        s0_valid = v0; s0_instr = i0; s0_pc = pc; s1_valid = v1; s1_instr = i1;
        cfg_disable = dis; flush = fl; fin_taken = tk;
        #1;
        e_fv = 0; e_fp = 0; e_wb = 0; e_rd = 0; e_tg = 0;
        foreach (q[k]) if (q[k].age == D - 1) begin
            e_fv = 1; e_fp = q[k].paired;
            e_wb = !fl && q[k].paired && !tk && q[k].rdnz;
            e_rd = !fl && !q[k].paired && tk;
            e_tg = q[k].tgt;
        end
        chk(tag, "pair_eligible", 32'(pair_eligible), 32'(b_elig(v0, i0, v1, i1, dis)));
        chk(tag, "fin_valid", 32'(fin_valid), 32'(e_fv));
        if (e_fv) chk(tag, "fin_paired", 32'(fin_paired), 32'(e_fp));
        chk(tag, "sh_wb_en", 32'(sh_wb_en), 32'(e_wb));
        chk(tag, "redirect_valid", 32'(redirect_valid), 32'(e_rd));
        if (e_rd) chk(tag, "redirect_target", redirect_target, e_tg);
        @(posedge clk);
        cyc_n++;
        if (fl) q.delete();
        else begin
            foreach (q[k]) q[k].age++;
            while (q.size() > 0 && q[0].age > D - 1) void'(q.pop_front());
            if (b_isbr(v0, i0))
                q.push_back('{b_elig(v0, i0, v1, i1, dis), i1[11:7] != 0,
                              pc + 32'(b_off(i0)), 0});
        end
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n, logic tk);
        for (int k = 0; k < n; k++) step(tag, 0, 32'h13, 0, 0, 32'h13, 0, 0, tk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; s0_valid = 0; s1_valid = 0; s0_instr = 0; s1_instr = 0; s0_pc = 0;
        cfg_disable = 0; flush = 0; fin_taken = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        idle("R11", 3, 1);
        // R7 pair with 32-bit OP, not taken
        step("R7", 1, mk_br(8, 3'd0), 32'h100, 1, mk_w(7'h33, 5'd5), 0, 0, 0);
        idle("R7", D, 0);
        // R6 pair taken with OP-IMM
        step("R6", 1, mk_br(8, 3'd1), 32'h200, 1, mk_w(7'h13, 5'd6), 0, 0, 1);
        idle("R6", D, 1);
        // R2 compressed forms, LUI, AUIPC
        step("R2", 1, mk_br(6, 3'd4), 32'h300, 1, mk_cli(5'd8), 0, 0, 0);
        step("R2", 1, mk_br(6, 3'd5), 32'h310, 1, mk_cmv(5'd9), 0, 0, 0);
        step("R2", 1, mk_br(8, 3'd6), 32'h320, 1, mk_w(7'h37, 5'd10), 0, 0, 1);
        step("R2", 1, mk_br(8, 3'd7), 32'h330, 1, mk_w(7'h17, 5'd11), 0, 0, 0);
        idle("R2", D, 0);
        // R3 load and store: ordinary branch, taken redirects
        step("R3", 1, mk_br(8, 3'd0), 32'h400, 1, mk_w(7'h03, 5'd12), 0, 0, 0);
        step("R3", 1, mk_br(8, 3'd0), 32'h410, 1, mk_w(7'h23, 5'd0), 0, 0, 0);
        idle("R3", D, 1);
        // R1 wrong offset, backward offset
        step("R1", 1, mk_br(12, 3'd0), 32'h500, 1, mk_w(7'h33, 5'd1), 0, 0, 0);
        step("R9", 1, mk_br(-16, 3'd1), 32'h600, 1, mk_w(7'h33, 5'd1), 0, 0, 0);
        step("R1", 1, mk_br(6, 3'd0), 32'h700, 1, mk_w(7'h33, 5'd1), 0, 0, 1);
        idle("R9", D, 1);
        // R4 disabled
        step("R4", 1, mk_br(8, 3'd0), 32'h800, 1, mk_w(7'h33, 5'd2), 1, 0, 0);
        idle("R4", D, 1);
        // R8 rd x0
        step("R8", 1, mk_br(8, 3'd0), 32'h900, 1, mk_w(7'h33, 5'd0), 0, 0, 0);
        idle("R8", D, 0);
        // R10 flush at final stage, and flush on issue
        step("R10", 1, mk_br(8, 3'd0), 32'hA00, 1, mk_w(7'h03, 5'd3), 0, 0, 0);
        idle("R10", D - 1, 1);
        step("R10", 1, mk_br(8, 3'd0), 32'hA10, 1, mk_w(7'h03, 5'd3), 0, 1, 1);
        idle("R10", D + 1, 1);
        // R5 randomized mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] i1;
            int sel = $urandom_range(0, 6);
            case (sel)
                0: i1 = mk_w(7'h33, 5'($urandom));
                1: i1 = mk_cli(5'($urandom));
                2: i1 = mk_cmv(5'($urandom));
                3: i1 = mk_w(7'h03, 5'($urandom));
                4: i1 = mk_w(7'h17, 5'($urandom));
                5: i1 = mk_cmv(5'd0) | 32'h0;
                default: i1 = mk_w(7'h13, 5'($urandom));
            endcase
            step("R5", $urandom_range(0, 3) != 0,
                 ($urandom_range(0, 4) == 0) ? mk_w(7'h33, 5'd1) :
                     mk_br(($urandom_range(0, 2) == 0) ? 6 : 8, 3'($urandom)),
                 32'($urandom) & 32'hFFFF_FFFE, $urandom_range(0, 5) != 0, i1,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 14) == 0,
                 1'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule